// File: doc/BRIEF.md
# Configuration Access Decoder and Router

This block sits on a host-side I/O request interface and provides the two-register configuration access scheme. A 32-bit address register, written through I/O port 0xCF8, selects a bus, device, function and dword register. A four-byte data window at 0xCFC..0xCFF then turns every read or write into one configuration transaction. Each transaction goes to one of three destinations: a small local register file, a hub port toward the primary bus, or a secondary bridge port.

Routing uses the bus and device numbers in the address register and the secondary and subordinate bus numbers held in the local bridge function's registers. On bus 0, devices 0, 1 and 6 are claimed locally. Each of them has its own bank of dwords, and device 6 is the test bank. Requests for other devices on bus 0 go to the hub port as Type 0. A nonzero bus inside the bridge's range goes to the bridge port; any other nonzero bus goes to the hub port as Type 1. The Type 0/Type 1 choice is an output flag next to the request fields.

The controller is a four-state machine:
- ST_IDLE takes one host request per pulse of `io_req`.
- ST_LOCAL performs one cycle of local register access.
- ST_EXT holds `cfg_valid` until `cfg_done`.
- ST_DONE raises `io_ack` for one cycle.

The transitions are:
- IDLE→DONE for address-port accesses, data-window accesses while disabled, and unclaimed addresses.
- IDLE→LOCAL for locally claimed requests.
- IDLE→EXT for routed external requests.
- LOCAL→DONE.
- EXT→DONE on `cfg_done`.
- DONE→IDLE.

Top module: `cfg_access_router`

## Requirements
- R1: After reset, `io_ack` and `cfg_valid` are low and the address register reads back as 0.
- R2: Only an I/O write to address 0x0CF8 with `io_be` = 4'b1111 loads the address register. A write there with any other byte enables leaves it unchanged. A read of 0x0CF8 with `io_be` = 4'b1111 returns its value.
- R3: An access to 0x0CFC..0x0CFF uses byte offset `io_addr[1:0]`. The lane mask is `io_be` shifted left by that offset, truncated to 4 bits, and write data is shifted left by 8×offset. Read data comes back as the selected dword shifted right by 8×offset.
- R4: While address bit 31 is 0, a data-window read returns 0xFFFFFFFF and a write is dropped. In both cases `cfg_valid` stays low and `io_ack` rises 1 cycle after the sampling edge.
- R5: On bus 0, devices 0, 1 and 6 are served locally. Each has its own bank of 16 dwords indexed by register bits [3:0], reset to 0. `cfg_valid` stays low and `io_ack` rises 2 cycles after the sampling edge.
- R6: A request to bus 0 with any other device number goes out with `cfg_to_bridge`=0 and `cfg_type1`=0.
- R7: A request to a nonzero bus below the secondary bus number or above the subordinate bus number goes out with `cfg_to_bridge`=0 and `cfg_type1`=1.
- R8: A request to a nonzero bus in secondary..subordinate (inclusive) goes out with `cfg_to_bridge`=1. `cfg_type1` is 0 when the bus equals the secondary number and 1 otherwise.
- R9: The secondary and subordinate numbers are bits [15:8] and [23:16] of dword 6 of the device-1 bank, so both are 0 after reset.
- R10: The external request carries the following fields from the address register: bus [23:16], device [15:11], function [10:8] and register [7:2]. It also carries the write flag, the lane mask and the shifted data. The request is held with `cfg_valid` until `cfg_done`, and `io_ack` follows in the next cycle.
- R11: `io_ack` is a one-cycle pulse. Any other I/O address, and a 0x0CF8 read with other byte enables, acknowledges with 0xFFFFFFFF and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_req | input | 1 | One-cycle I/O request strobe, taken in ST_IDLE |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables relative to the addressed byte |
| io_wdata | input | 32 | Write data, low byte first |
| io_ack | output | 1 | Completion pulse |
| io_rdata | output | 32 | Read data, valid with `io_ack` |
| cfg_valid | output | 1 | External configuration request pending |
| cfg_to_bridge | output | 1 | 1 = bridge port, 0 = hub port |
| cfg_type1 | output | 1 | 1 = Type 1 cycle, 0 = Type 0 |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Dword lane mask |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_done | input | 1 | One-cycle completion from the selected port |
| cfg_rdata | input | 32 | Read data with `cfg_done` |

## Verification
Counting from the clock edge that samples `io_req`, the acknowledge of an address-port access, a disabled data-window access or an unclaimed address is due 1 edge later. A local access is due 2 edges later. An external access is acknowledged 1 edge after the edge that samples `cfg_done`. The driver records the edge at which each request is taken and queues the expected latency and read data. The monitor samples at falling edges and compares the measured edge count and data against the queued item. A responder pops queued request expectations whenever `cfg_valid` is seen and fails any request it was not told to expect.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    localparam logic [15:0] CFGR_ADDR_PORT = 16'h0CF8;
    localparam logic [15:0] CFGR_DATA_PORT = 16'h0CFC;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOCAL,
        ST_EXT,
        ST_DONE
    } cfgr_state_e;

    typedef enum logic [1:0] {
        DST_NONE,
        DST_LOCAL,
        DST_HUB,
        DST_BRIDGE
    } cfgr_dest_e;

    typedef struct packed {
        cfgr_dest_e dest;
        logic       type1;
        logic [1:0] bank;
    } cfgr_route_t;

endpackage

// File: rtl/cfgr_route_decode.sv
module cfgr_route_decode
    import cfgr_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int DEV_W    = 5,
    parameter int HUB_DEV  = 0,
    parameter int BRG_DEV  = 1,
    parameter int TEST_DEV = 6
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output cfgr_route_t      route
);

    localparam logic [DEV_W-1:0] D_HUB  = DEV_W'(HUB_DEV);
    localparam logic [DEV_W-1:0] D_BRG  = DEV_W'(BRG_DEV);
    localparam logic [DEV_W-1:0] D_TEST = DEV_W'(TEST_DEV);

    logic bus_zero;
    logic in_range;

    assign bus_zero = (bus == '0);
    assign in_range = (bus >= sec_bus) && (bus <= sub_bus);

    always_comb begin
        route = '{dest: DST_HUB, type1: 1'b1, bank: 2'd0};
        if (bus_zero) begin
            route.type1 = 1'b0;
            if (dev == D_HUB) begin
                route.dest = DST_LOCAL;
                route.bank = 2'd0;
            end else if (dev == D_BRG) begin
                route.dest = DST_LOCAL;
                route.bank = 2'd1;
            end else if (dev == D_TEST) begin
                route.dest = DST_LOCAL;
                route.bank = 2'd2;
            end
        end else if (in_range) begin
            route.dest  = DST_BRIDGE;
            route.type1 = (bus != sec_bus);
        end
    end

endmodule

// File: rtl/cfgr_local_regs.sv
module cfgr_local_regs #(
    parameter int DWORDS  = 16,
    parameter int BUS_W   = 8,
    parameter int BRG_IDX = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_en,
    input  logic                      acc_wr,
    input  logic [1:0]                bank,
    input  logic [$clog2(DWORDS)-1:0] idx,
    input  logic [3:0]                be,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output logic [BUS_W-1:0]          sec_bus,
    output logic [BUS_W-1:0]          sub_bus
);

    localparam int NBANKS = 3;
    localparam int LANES  = 4;

    logic [31:0] mem [NBANKS][DWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANKS; b++) begin
                for (int w = 0; w < DWORDS; w++) begin
                    mem[b][w] <= '0;
                end
            end
        end else if (acc_en && acc_wr && (bank < 2'(NBANKS))) begin
            for (int l = 0; l < LANES; l++) begin
                if (be[l]) begin
                    mem[bank][idx][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
    end

    assign rdata   = (bank < 2'(NBANKS)) ? mem[bank][idx] : '1;
    assign sec_bus = mem[1][BRG_IDX][8  +: BUS_W];
    assign sub_bus = mem[1][BRG_IDX][16 +: BUS_W];

    AST_SEC_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_wr && bank == 2'd1 && idx == ($clog2(DWORDS))'(BRG_IDX) && be[1]
        |=> sec_bus == $past(wdata[15:8])); // R9

    AST_SUB_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_wr && bank == 2'd1 && idx == ($clog2(DWORDS))'(BRG_IDX) && be[2]
        |=> sub_bus == $past(wdata[23:16])); // R9

endmodule

// File: rtl/cfgr_ctrl.sv
module cfgr_ctrl
    import cfgr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [15:0]       io_addr,
    input  logic [3:0]        io_be,
    input  logic [31:0]       io_wdata,
    output logic              io_ack,
    output logic [31:0]       io_rdata,
    input  cfgr_route_t       route,
    output logic [31:0]       addr_q,
    output logic              loc_en,
    output logic              loc_wr,
    output logic [1:0]        loc_bank,
    output logic [IDX_W-1:0]  loc_idx,
    output logic [3:0]        loc_be,
    output logic [31:0]       loc_wdata,
    input  logic [31:0]       loc_rdata,
    output logic              cfg_valid,
    output logic              cfg_to_bridge,
    output logic              cfg_type1,
    output logic              cfg_write,
    output logic [7:0]        cfg_bus,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_func,
    output logic [5:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_done,
    input  logic [31:0]       cfg_rdata
);

    cfgr_state_e state, state_nx;

    logic        hit_addr;
    logic        hit_data;
    logic [6:0]  be_wide;
    logic [31:0] wd_shift;

    logic        op_wr;
    logic [1:0]  op_lane;
    logic [3:0]  op_be;
    logic [31:0] op_wdata;
    cfgr_route_t op_route;
    logic [31:0] rdata_q;

    assign hit_addr = (io_addr == CFGR_ADDR_PORT) && (io_be == 4'hF);
    assign hit_data = (io_addr[15:2] == CFGR_DATA_PORT[15:2]);
    assign be_wide  = {3'b000, io_be} << io_addr[1:0];
    assign wd_shift = io_wdata << {io_addr[1:0], 3'b000};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (io_req) begin
                    if (hit_data && addr_q[31] && !hit_addr) begin
                        state_nx = (route.dest == DST_LOCAL) ? ST_LOCAL : ST_EXT;
                    end else begin
                        state_nx = ST_DONE;
                    end
                end
            end
            ST_LOCAL: state_nx = ST_DONE;
            ST_EXT:   if (cfg_done) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            op_wr    <= 1'b0;
            op_lane  <= '0;
            op_be    <= '0;
            op_wdata <= '0;
            op_route <= '{dest: DST_NONE, type1: 1'b0, bank: 2'd0};
            rdata_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (io_req) begin
                        if (hit_addr) begin
                            if (io_wr) addr_q  <= io_wdata;
                            else       rdata_q <= addr_q;
                        end else if (hit_data && addr_q[31]) begin
                            op_wr    <= io_wr;
                            op_lane  <= io_addr[1:0];
                            op_be    <= be_wide[3:0];
                            op_wdata <= wd_shift;
                            op_route <= route;
                        end else begin
                            rdata_q <= '1;
                        end
                    end
                end
                ST_LOCAL: rdata_q <= loc_rdata >> {op_lane, 3'b000};
                ST_EXT:   if (cfg_done) rdata_q <= cfg_rdata >> {op_lane, 3'b000};
                ST_DONE:  ;
                default:  ;
            endcase
        end
    end

    always_comb begin
        io_ack        = (state == ST_DONE);
        io_rdata      = rdata_q;
        loc_en        = (state == ST_LOCAL);
        loc_wr        = op_wr;
        loc_bank      = op_route.bank;
        loc_idx       = addr_q[2 +: IDX_W];
        loc_be        = op_be;
        loc_wdata     = op_wdata;
        cfg_valid     = (state == ST_EXT);
        cfg_to_bridge = (op_route.dest == DST_BRIDGE);
        cfg_type1     = op_route.type1;
        cfg_write     = op_wr;
        cfg_bus       = addr_q[23:16];
        cfg_dev       = addr_q[15:11];
        cfg_func      = addr_q[10:8];
        cfg_reg       = addr_q[7:2];
        cfg_be        = op_be;
        cfg_wdata     = op_wdata;
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |=> !io_ack); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_done |=> cfg_valid &&
            $stable({cfg_bus, cfg_dev, cfg_func, cfg_reg, cfg_be, cfg_wdata, cfg_write})); // R10

    AST_DONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_done |=> io_ack && !cfg_valid); // R10

    AST_OFF_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && io_req && hit_data && !addr_q[31] |=> io_ack && !cfg_valid); // R4

    AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && io_req && io_wr && io_addr == CFGR_ADDR_PORT && io_be != 4'hF
        |=> addr_q == $past(addr_q)); // R2

    AST_HUB_TYPE0_BUS0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_to_bridge && !cfg_type1 |-> cfg_bus == 8'd0); // R6

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfgr_pkg::*;
#(
    parameter int DWORDS   = 16,
    parameter int BRG_IDX  = 6,
    parameter int HUB_DEV  = 0,
    parameter int BRG_DEV  = 1,
    parameter int TEST_DEV = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_req,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [3:0]  io_be,
    input  logic [31:0] io_wdata,
    output logic        io_ack,
    output logic [31:0] io_rdata,
    output logic        cfg_valid,
    output logic        cfg_to_bridge,
    output logic        cfg_type1,
    output logic        cfg_write,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_func,
    output logic [5:0]  cfg_reg,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_done,
    input  logic [31:0] cfg_rdata
);

    localparam int IDX_W = $clog2(DWORDS);
    localparam int BUS_W = 8;

    cfgr_route_t      route;
    logic [31:0]      addr_q;
    logic             loc_en, loc_wr;
    logic [1:0]       loc_bank;
    logic [IDX_W-1:0] loc_idx;
    logic [3:0]       loc_be;
    logic [31:0]      loc_wdata, loc_rdata;
    logic [BUS_W-1:0] sec_bus, sub_bus;

    cfgr_route_decode #(
        .BUS_W(BUS_W), .DEV_W(5),
        .HUB_DEV(HUB_DEV), .BRG_DEV(BRG_DEV), .TEST_DEV(TEST_DEV)
    ) u_decode (
        .bus(addr_q[23:16]), .dev(addr_q[15:11]),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .route(route)
    );

    cfgr_local_regs #(
        .DWORDS(DWORDS), .BUS_W(BUS_W), .BRG_IDX(BRG_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(loc_en), .acc_wr(loc_wr),
        .bank(loc_bank), .idx(loc_idx), .be(loc_be), .wdata(loc_wdata),
        .rdata(loc_rdata), .sec_bus(sec_bus), .sub_bus(sub_bus)
    );

    cfgr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be),
        .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
        .route(route), .addr_q(addr_q),
        .loc_en(loc_en), .loc_wr(loc_wr), .loc_bank(loc_bank), .loc_idx(loc_idx),
        .loc_be(loc_be), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .cfg_valid(cfg_valid), .cfg_to_bridge(cfg_to_bridge), .cfg_type1(cfg_type1),
        .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_done(cfg_done), .cfg_rdata(cfg_rdata)
    );

    AST_BRIDGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_to_bridge |-> cfg_bus != 8'd0 && cfg_bus >= sec_bus && cfg_bus <= sub_bus); // R8

    AST_LOCAL_NOT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        loc_en |-> !cfg_valid); // R5

endmodule

// File: tb/cfg_access_router_test.sv
module cfg_access_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ack;
    logic [31:0] io_rdata;
    logic        cfg_valid, cfg_to_bridge, cfg_type1, cfg_write;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_done = 1'b0;
    logic [31:0] cfg_rdata = '0;

    cfg_access_router uut (.*);

    always #5 clk = ~clk;

    typedef struct {
        bit          chk_data;
        logic [31:0] rdata;
        int          lat;
        int          req_cyc;
        string       tag;
    } ack_item_t;

    typedef struct {
        bit          bridge, type1, write;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  func;
        logic [5:0]  rg;
        logic [3:0]  be;
        logic [31:0] wdata, resp;
        string       tag;
    } ext_item_t;

    ack_item_t ack_q[$];
    ext_item_t ext_q[$];
    int total = 0, bad = 0, cyc = 0, acks = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] caddr(input int bus, input int dev, input int fn, input int rg);
        return {1'b1, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_op(input bit wr, input logic [15:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input bit chk, input logic [31:0] exp,
                         input int lat, input string tag);
        ack_item_t it;
        int start;
        @(negedge clk);
        it.chk_data = chk; it.rdata = exp; it.lat = lat; it.req_cyc = cyc + 1; it.tag = tag;
        ack_q.push_back(it);
        start = acks;
        io_req = 1'b1; io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0; io_wdata = '0;
        while (acks == start) @(negedge clk);
    endtask

    task automatic ext_exp(input bit br, input bit t1, input bit wr, input int bus, input int dev,
                           input int fn, input int rg, input logic [3:0] be,
                           input logic [31:0] wd, input logic [31:0] resp, input string tag);
        ext_item_t e;
        e.bridge = br; e.type1 = t1; e.write = wr; e.bus = 8'(bus); e.dev = 5'(dev);
        e.func = 3'(fn); e.rg = 6'(rg); e.be = be; e.wdata = wd; e.resp = resp; e.tag = tag;
        ext_q.push_back(e);
    endtask

    // monitor: compares each acknowledge against the queued expectation
    always @(negedge clk) begin
        if (rst_n && io_ack) begin
            if (ack_q.size() == 0) begin
                check(1'b0, "R11 unexpected ack", 32'd1, 32'd0);
            end else begin
                ack_item_t it;
                it = ack_q.pop_front();
                if (it.chk_data)
                    check(io_rdata === it.rdata, it.tag, io_rdata, it.rdata);
                if (it.lat > 0)
                    check((cyc - it.req_cyc + 1) == it.lat, {it.tag, " latency"},
                          32'(cyc - it.req_cyc + 1), 32'(it.lat));
            end
            acks++;
        end
    end

    // responder: plays the hub/bridge port
    always @(negedge clk) begin
        if (cfg_done) begin
            cfg_done <= 1'b0;
        end else if (rst_n && cfg_valid) begin
            if (ext_q.size() == 0) begin
                check(1'b0, "R4 R5 unexpected cfg_valid", {24'd0, cfg_bus}, 32'd0);
            end else begin
                ext_item_t e;
                logic [31:0] act, exp;
                e = ext_q.pop_front();
                act = {cfg_to_bridge, cfg_type1, cfg_write, 1'b0, cfg_be, cfg_bus, cfg_dev, cfg_func, cfg_reg, 2'b0};
                exp = {e.bridge, e.type1, e.write, 1'b0, e.be, e.bus, e.dev, e.func, e.rg, 2'b0};
                check(act == exp, {e.tag, " R10 fields"}, act, exp);
                if (e.write) check(cfg_wdata == e.wdata, {e.tag, " R10 wdata"}, cfg_wdata, e.wdata);
                cfg_rdata <= e.resp;
            end
            cfg_done <= 1'b1;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'(cyc), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [15:0] AP = 16'h0CF8;
    localparam logic [15:0] DP = 16'h0CFC;

    initial begin
        repeat (3) @(negedge clk);
        check(io_ack == 1'b0 && cfg_valid == 1'b0, "R1 outputs in reset", {io_ack, cfg_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(io_ack == 1'b0 && cfg_valid == 1'b0, "R1 outputs after reset", {io_ack, cfg_valid}, 0);
        io_op(0, AP, 4'hF, 0, 1, 32'h0, 1, "R1 address reg reset");

        // R4 disabled window
        io_op(0, DP, 4'hF, 0, 1, 32'hFFFF_FFFF, 1, "R4 disabled read");
        io_op(1, DP, 4'hF, 32'hDEAD_BEEF, 0, 0, 1, "R4 disabled write");
        io_op(1, AP, 4'hF, 32'h8000_0000, 0, 0, 1, "R2 load address");
        io_op(0, DP, 4'hF, 0, 1, 32'h0, 2, "R4 write was dropped / R5 latency");

        // R2 narrow accesses, R11 unclaimed
        io_op(1, AP, 4'h3, 32'h0000_FFFF, 0, 0, 1, "R2 narrow write");
        io_op(0, AP, 4'hF, 0, 1, 32'h8000_0000, 1, "R2 narrow write ignored");
        io_op(0, AP, 4'h1, 0, 1, 32'hFFFF_FFFF, 1, "R11 narrow address read");
        io_op(0, 16'h0CF0, 4'hF, 0, 1, 32'hFFFF_FFFF, 1, "R11 other address");

        // R5 local bank 0
        io_op(1, AP, 4'hF, caddr(0, 0, 0, 4), 0, 0, 1, "R2 load");
        io_op(1, DP, 4'hF, 32'h1234_5678, 0, 0, 2, "R5 local write");
        io_op(0, DP, 4'hF, 0, 1, 32'h1234_5678, 2, "R5 local readback");

        // R3 byte lanes
        io_op(1, DP + 16'd2, 4'h1, 32'h0000_00AB, 0, 0, 2, "R3 lane2 write");
        io_op(0, DP, 4'hF, 0, 1, 32'h12AB_5678, 2, "R3 lane2 merged");
        io_op(0, DP + 16'd1, 4'h1, 0, 1, 32'h0012_AB56, 2, "R3 offset read");

        // R5 test bank is separate
        io_op(1, AP, 4'hF, caddr(0, 6, 0, 4), 0, 0, 1, "R2 load");
        io_op(1, DP, 4'hF, 32'hCAFE_F00D, 0, 0, 2, "R5 test bank write");
        io_op(0, DP, 4'hF, 0, 1, 32'hCAFE_F00D, 2, "R5 test bank read");
        io_op(1, AP, 4'hF, caddr(0, 0, 0, 4), 0, 0, 1, "R2 load");
        io_op(0, DP, 4'hF, 0, 1, 32'h12AB_5678, 2, "R5 bank 0 untouched");

        // R6 bus 0 other device
        io_op(1, AP, 4'hF, caddr(0, 3, 2, 9), 0, 0, 1, "R2 load");
        ext_exp(0, 0, 0, 0, 3, 2, 9, 4'hF, 0, 32'h1122_3344, "R6 hub type0");
        io_op(0, DP, 4'hF, 0, 1, 32'h1122_3344, 0, "R6 read data");
        ext_exp(0, 0, 0, 0, 3, 2, 9, 4'h8, 0, 32'hA1B2_C3D4, "R6 R3 byte lane");
        io_op(0, DP + 16'd3, 4'h1, 0, 1, 32'h0000_00A1, 0, "R3 R10 shifted read");

        // R7 nonzero bus, bridge range empty after reset (R9)
        io_op(1, AP, 4'hF, caddr(5, 2, 1, 3), 0, 0, 1, "R2 load");
        ext_exp(0, 1, 1, 5, 2, 1, 3, 4'hF, 32'h55AA_55AA, 0, "R7 R9 hub type1 write");
        io_op(1, DP, 4'hF, 32'h55AA_55AA, 0, 0, 0, "R7 write");

        // R9 program bridge range: secondary 4, subordinate 8
        io_op(1, AP, 4'hF, caddr(0, 1, 0, 6), 0, 0, 1, "R2 load");
        io_op(1, DP, 4'hF, 32'h0008_0400, 0, 0, 2, "R9 bus numbers");
        io_op(0, DP, 4'hF, 0, 1, 32'h0008_0400, 2, "R9 readback");

        // R8 / R7 range edges
        io_op(1, AP, 4'hF, caddr(4, 0, 0, 0), 0, 0, 1, "R2 load");
        ext_exp(1, 0, 0, 4, 0, 0, 0, 4'hF, 0, 32'h0000_0004, "R8 secondary type0");
        io_op(0, DP, 4'hF, 0, 1, 32'h0000_0004, 0, "R8 secondary read");
        io_op(1, AP, 4'hF, caddr(7, 9, 3, 17), 0, 0, 1, "R2 load");
        ext_exp(1, 1, 0, 7, 9, 3, 17, 4'hF, 0, 32'h0000_0007, "R8 inside type1");
        io_op(0, DP, 4'hF, 0, 1, 32'h0000_0007, 0, "R8 inside read");
        io_op(1, AP, 4'hF, caddr(8, 31, 7, 63), 0, 0, 1, "R2 load");
        ext_exp(1, 1, 0, 8, 31, 7, 63, 4'hF, 0, 32'h0000_0008, "R8 subordinate edge");
        io_op(0, DP, 4'hF, 0, 1, 32'h0000_0008, 0, "R8 subordinate read");
        io_op(1, AP, 4'hF, caddr(9, 1, 0, 0), 0, 0, 1, "R2 load");
        ext_exp(0, 1, 0, 9, 1, 0, 0, 4'hF, 0, 32'h0000_0009, "R7 above subordinate");
        io_op(0, DP, 4'hF, 0, 1, 32'h0000_0009, 0, "R7 above read");
        io_op(1, AP, 4'hF, caddr(3, 1, 0, 0), 0, 0, 1, "R2 load");
        ext_exp(0, 1, 0, 3, 1, 0, 0, 4'hF, 0, 32'h0000_0003, "R7 below secondary");
        io_op(0, DP, 4'hF, 0, 1, 32'h0000_0003, 0, "R7 below read");

        // R3 R8 lane-shifted write to bridge
        io_op(1, AP, 4'hF, caddr(6, 1, 0, 2), 0, 0, 1, "R2 load");
        ext_exp(1, 1, 1, 6, 1, 0, 2, 4'h6, 32'h00BE_EF00, 0, "R3 R8 shifted write");
        io_op(1, DP + 16'd1, 4'h3, 32'h0000_BEEF, 0, 0, 0, "R3 shifted write");

        // R4 disabled again: no request
        io_op(1, AP, 4'hF, caddr(4, 0, 0, 0) & 32'h7FFF_FFFF, 0, 0, 1, "R2 load");
        io_op(0, DP, 4'hF, 0, 1, 32'hFFFF_FFFF, 1, "R4 disabled bridge read");

        repeat (4) @(negedge clk);
        check(ext_q.size() == 0 && ack_q.size() == 0, "R10 queues drained",
              32'(ext_q.size() + ack_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule